// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block sits beside a processor's exception logic and decides, every cycle, what happens to an incoming fault. Three configurable fault kinds (memory-management, bus, usage) each carry a programmable priority and a handler-enable bit. The block picks the most urgent pending fault. It then either lets the fault's own handler run, or promotes the fault to a hard fault when that handler could not run: the handler is disabled, the fault's priority does not beat the current execution priority, or the fault was raised by the handler that services that same fault kind. One exception applies. A bus fault raised while the entry frame of the bus fault handler is being pushed is never promoted.

A hard fault raised while the hard fault handler or the NMI handler is running cannot be serviced. The block then enters a lockup state that inhibits instruction execution. Lockup ends on reset, on a debug halt request or on NMI. NMI does not release a lockup that was entered from the NMI handler. The decision outputs and the lockup flag are registered, so they appear one clock after the inputs that cause them.

Top module: `fault_escalation_ctrl`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `sel` is 0, `sel_id` is 0, and `escalated`, `lockup` and `exec_inhibit` are all 0.
- R2: Fault bits are bit 0 memory-management, bit 1 bus, bit 2 usage. Among the pending faults the one with the lowest priority value wins, and ties go to bit 0, then bit 1, then bit 2. `sel` encodes 0 none, 1 configurable handler, 2 hard fault. `sel_id` carries the winner's bit index when `sel` is 1 and is 0 otherwise. With no request and no hard request, `sel` is 0 one cycle later.
- R3: `ctx` encodes 0 thread, 1 memory-management handler, 2 bus handler, 3 usage handler, 4 hard fault handler, 5 NMI handler. A winning fault that is enabled, whose priority value is strictly less than `cur_prio`, and that is not raised in its own handler, the hard fault handler or the NMI handler gives `sel`=1 with `escalated`=0 one cycle later.
- R4: A winning fault whose priority value is equal to or greater than `cur_prio` gives `sel`=2 with `escalated`=1 one cycle later.
- R5: A winning fault whose bit in `flt_en` is 0 is promoted (`sel`=2, `escalated`=1) whatever its priority.
- R6: A winning fault raised in the handler context of the same fault kind is promoted whatever its priority.
- R7: A bus fault that wins while `stack_push` is 1 is never promoted: `sel`=1, `sel_id`=1, `escalated`=0.
- R8: `hard_req`, or a promoted fault, in context 0 to 3 gives `sel`=2 one cycle later. `escalated` is 1 only when a configurable fault was promoted.
- R9: A hard fault (from `hard_req` or a promoted fault) in context 4 or 5 gives `sel`=0, `lockup`=1 and `exec_inhibit`=1 one cycle later. `escalated` reports promotion in that same cycle.
- R10: While locked, fault and hard requests are ignored: `sel` stays 0 and the block stays locked.
- R11: A lockup entered from context 4 is left one cycle after either `nmi` or `dbg_halt` is 1.
- R12: A lockup entered from context 5 is not left on `nmi`. It is left one cycle after `dbg_halt` is 1.
- R13: Asserting `rst_n` low clears lockup at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_req | input | 3 | Configurable fault requests, one bit per kind |
| flt_en | input | 3 | Handler-enable mask, one bit per kind |
| prio_mm | input | PW | Priority value of the memory-management fault |
| prio_bus | input | PW | Priority value of the bus fault |
| prio_use | input | PW | Priority value of the usage fault |
| cur_prio | input | PW | Current execution priority value |
| ctx | input | 3 | Current execution context code |
| stack_push | input | 1 | Entry frame push for the bus fault handler in progress |
| hard_req | input | 1 | Direct hard fault request |
| nmi | input | 1 | NMI request |
| dbg_halt | input | 1 | Debug halt request |
| sel | output | 2 | Selected exception: 0 none, 1 configurable, 2 hard fault |
| sel_id | output | 2 | Index of the selected configurable fault |
| escalated | output | 1 | A configurable fault was promoted to hard fault |
| lockup | output | 1 | Lockup state active |
| exec_inhibit | output | 1 | Instruction execution inhibited |

## Verification
The bench builds the block with the default PW=3, so it has eight priority levels. This lets a single vector place a fault's priority strictly above, equal to or below `cur_prio`, and lets three pending faults hold distinct or equal values, so every winner and every tie order can be reached. With this width the extreme values 0 and 7 are also cheap to reach. The bench uses them to show that handler-context and disable promotion ignore priority, and that the push exemption overrides a priority that would otherwise promote the bus fault.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int NF = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_HARD = 2'd2
    } sel_e;

    typedef enum logic [2:0] {
        CTX_THREAD = 3'd0,
        CTX_MM     = 3'd1,
        CTX_BUS    = 3'd2,
        CTX_USE    = 3'd3,
        CTX_HARD   = 3'd4,
        CTX_NMI    = 3'd5
    } ctx_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_LOCK_HF  = 2'd1,
        ST_LOCK_NMI = 2'd2
    } lock_st_e;

    localparam logic [1:0] IDX_BUS = 2'd1;
endpackage

// File: rtl/fe_pick.sv
module fe_pick
    import fe_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic [NF-1:0]         req,
    input  logic [NF-1:0][PW-1:0] prio,
    output logic                  found,
    output logic [1:0]            win
);
    logic [PW-1:0] best;

    // strict compare keeps the lower index on equal priority values
    always_comb begin
        found = 1'b0;
        win   = 2'd0;
        best  = '0;
        for (int i = 0; i < NF; i++) begin
            if (req[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                win   = 2'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/fe_escalate.sv
module fe_escalate
    import fe_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic                  found,
    input  logic [1:0]            win,
    input  logic [NF-1:0]         en,
    input  logic [NF-1:0][PW-1:0] prio,
    input  logic [PW-1:0]         cur_prio,
    input  logic [2:0]            ctx,
    input  logic                  stack_push,
    input  logic                  hard_req,
    output logic                  promote_out,
    output logic                  hard_out
);
    logic [NF-1:0] promote;
    logic          fixed_ctx;
    logic          exempt;

    assign fixed_ctx = (ctx == CTX_HARD) || (ctx == CTX_NMI);

    for (genvar g = 0; g < NF; g++) begin : g_cond
        assign promote[g] = !en[g]
                         || (prio[g] >= cur_prio)
                         || (ctx == 3'(g + 1))
                         || fixed_ctx;
    end

    assign exempt      = (win == IDX_BUS) && stack_push;
    assign promote_out = found && promote[win] && !exempt;
    assign hard_out    = promote_out || hard_req;
endmodule

// File: rtl/fe_lock_fsm.sv
module fe_lock_fsm
    import fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       found,
    input  logic [1:0] win,
    input  logic       promote,
    input  logic       hard,
    input  logic [2:0] ctx,
    input  logic       nmi,
    input  logic       dbg_halt,
    output logic [1:0] sel,
    output logic [1:0] sel_id,
    output logic       escalated,
    output logic       lockup,
    output logic       exec_inhibit
);
    lock_st_e state, state_nx;
    logic     fixed_ctx;

    assign fixed_ctx = (ctx == CTX_HARD) || (ctx == CTX_NMI);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (hard && ctx == CTX_NMI)       state_nx = ST_LOCK_NMI;
                else if (hard && ctx == CTX_HARD) state_nx = ST_LOCK_HF;
            end
            ST_LOCK_HF:  if (nmi || dbg_halt) state_nx = ST_RUN;
            ST_LOCK_NMI: if (dbg_halt)        state_nx = ST_RUN;
            default:     state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel       <= SEL_NONE;
            sel_id    <= 2'd0;
            escalated <= 1'b0;
        end else begin
            sel       <= SEL_NONE;
            sel_id    <= 2'd0;
            escalated <= 1'b0;
            if (state == ST_RUN) begin
                if (hard) begin
                    escalated <= promote;
                    if (!fixed_ctx) sel <= SEL_HARD;
                end else if (found) begin
                    sel    <= SEL_CFG;
                    sel_id <= win;
                end
            end
        end
    end

    assign lockup       = (state != ST_RUN);
    assign exec_inhibit = (state != ST_RUN);
endmodule

// File: rtl/fault_escalation_ctrl.sv
module fault_escalation_ctrl
    import fe_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    flt_req,
    input  logic [2:0]    flt_en,
    input  logic [PW-1:0] prio_mm,
    input  logic [PW-1:0] prio_bus,
    input  logic [PW-1:0] prio_use,
    input  logic [PW-1:0] cur_prio,
    input  logic [2:0]    ctx,
    input  logic          stack_push,
    input  logic          hard_req,
    input  logic          nmi,
    input  logic          dbg_halt,
    output logic [1:0]    sel,
    output logic [1:0]    sel_id,
    output logic          escalated,
    output logic          lockup,
    output logic          exec_inhibit
);
    logic [NF-1:0][PW-1:0] prio;
    logic                  found;
    logic [1:0]            win;
    logic                  promote;
    logic                  hard;

    assign prio = {prio_use, prio_bus, prio_mm};

    fe_pick #(.PW(PW)) u_pick (
        .req   (flt_req),
        .prio  (prio),
        .found (found),
        .win   (win)
    );

    fe_escalate #(.PW(PW)) u_esc (
        .found       (found),
        .win         (win),
        .en          (flt_en),
        .prio        (prio),
        .cur_prio    (cur_prio),
        .ctx         (ctx),
        .stack_push  (stack_push),
        .hard_req    (hard_req),
        .promote_out (promote),
        .hard_out    (hard)
    );

    fe_lock_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .found        (found),
        .win          (win),
        .promote      (promote),
        .hard         (hard),
        .ctx          (ctx),
        .nmi          (nmi),
        .dbg_halt     (dbg_halt),
        .sel          (sel),
        .sel_id       (sel_id),
        .escalated    (escalated),
        .lockup       (lockup),
        .exec_inhibit (exec_inhibit)
    );
endmodule

// File: rtl/fe_chk.sv
module fe_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    flt_req,
    input logic [2:0]    flt_en,
    input logic [2:0]    ctx,
    input logic          stack_push,
    input logic          hard_req,
    input logic          dbg_halt,
    input logic [1:0]    sel,
    input logic [1:0]    sel_id,
    input logic          escalated,
    input logic          lockup,
    input logic          exec_inhibit
);
    a_r2_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'd3);

    a_r2_id_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 2'd1) |-> (sel_id == 2'd0));

    a_r5_disabled_promotes: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockup && flt_req == 3'b001 && !flt_en[0] && !hard_req && ctx == 3'd0)
        |=> (sel == 2'd2 && escalated));

    a_r7_push_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockup && flt_req == 3'b010 && stack_push && !hard_req)
        |=> (sel == 2'd1 && sel_id == 2'd1 && !escalated));

    a_r9_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockup && hard_req && (ctx == 3'd4 || ctx == 3'd5))
        |=> (lockup && exec_inhibit && sel == 2'd0));

    a_r10_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> (sel == 2'd0));

    a_r11_dbg_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup && dbg_halt) |=> !lockup);
endmodule

bind fault_escalation_ctrl fe_chk #(.PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_req      (flt_req),
    .flt_en       (flt_en),
    .ctx          (ctx),
    .stack_push   (stack_push),
    .hard_req     (hard_req),
    .dbg_halt     (dbg_halt),
    .sel          (sel),
    .sel_id       (sel_id),
    .escalated    (escalated),
    .lockup       (lockup),
    .exec_inhibit (exec_inhibit)
);

// File: tb/sim_fault_escalation_ctrl.sv
module sim_fault_escalation_ctrl;
    localparam int PW     = 3;
    localparam int CLK_NS = 10;

    typedef struct packed {
        logic [3:0]    rq;
        logic [2:0]    req;
        logic [2:0]    en;
        logic [PW-1:0] pm;
        logic [PW-1:0] pb;
        logic [PW-1:0] pu;
        logic [PW-1:0] cp;
        logic [2:0]    cx;
        logic          sp;
        logic          hr;
        logic [1:0]    esel;
        logic [1:0]    eid;
        logic          eesc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  3'b001, 3'b111, 3'd2, 3'd0, 3'd0, 3'd5, 3'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0}, // R3
        '{4'd4,  3'b010, 3'b111, 3'd0, 3'd5, 3'd0, 3'd5, 3'd0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R4 equal
        '{4'd4,  3'b100, 3'b111, 3'd0, 3'd0, 3'd6, 3'd5, 3'd0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R4 lower
        '{4'd5,  3'b001, 3'b110, 3'd0, 3'd0, 3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R5
        '{4'd2,  3'b111, 3'b111, 3'd3, 3'd1, 3'd2, 3'd7, 3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0}, // R2 lowest
        '{4'd2,  3'b111, 3'b111, 3'd2, 3'd2, 3'd2, 3'd7, 3'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0}, // R2 tie all
        '{4'd2,  3'b110, 3'b111, 3'd0, 3'd4, 3'd4, 3'd7, 3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0}, // R2 tie bus
        '{4'd2,  3'b101, 3'b111, 3'd5, 3'd0, 3'd1, 3'd7, 3'd0, 1'b0, 1'b0, 2'd1, 2'd2, 1'b0}, // R2 usage
        '{4'd6,  3'b100, 3'b111, 3'd0, 3'd0, 3'd0, 3'd7, 3'd3, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R6 usage
        '{4'd6,  3'b001, 3'b111, 3'd0, 3'd0, 3'd0, 3'd7, 3'd1, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R6 mm
        '{4'd7,  3'b010, 3'b111, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0}, // R7
        '{4'd6,  3'b010, 3'b111, 3'd0, 3'd0, 3'd0, 3'd7, 3'd2, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1}, // R6 bus
        '{4'd8,  3'b000, 3'b111, 3'd0, 3'd0, 3'd0, 3'd7, 3'd1, 1'b0, 1'b1, 2'd2, 2'd0, 1'b0}, // R8
        '{4'd2,  3'b000, 3'b111, 3'd0, 3'd0, 3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0}  // R2 idle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    flt_req = '0;
    logic [2:0]    flt_en = '0;
    logic [PW-1:0] prio_mm = '0, prio_bus = '0, prio_use = '0, cur_prio = '0;
    logic [2:0]    ctx = '0;
    logic          stack_push = 1'b0, hard_req = 1'b0, nmi = 1'b0, dbg_halt = 1'b0;
    logic [1:0]    sel, sel_id;
    logic          escalated, lockup, exec_inhibit;
    int            total = 0;
    int            bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    fault_escalation_ctrl #(.PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_en(flt_en),
        .prio_mm(prio_mm), .prio_bus(prio_bus), .prio_use(prio_use),
        .cur_prio(cur_prio), .ctx(ctx), .stack_push(stack_push),
        .hard_req(hard_req), .nmi(nmi), .dbg_halt(dbg_halt),
        .sel(sel), .sel_id(sel_id), .escalated(escalated),
        .lockup(lockup), .exec_inhibit(exec_inhibit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        flt_req = '0; hard_req = 0; nmi = 0; dbg_halt = 0; stack_push = 0;
        flt_en = 3'b111; ctx = 3'd0; cur_prio = 3'd7;
    endtask

    // drive at a falling edge, result is sampled at the following falling edge
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 20000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet();
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 sel", sel, 0);
        chk("R1 lockup", lockup, 0);
        chk("R1 inhibit", exec_inhibit, 0);
        chk("R1 esc", escalated, 0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            flt_req = VEC[v].req; flt_en = VEC[v].en;
            prio_mm = VEC[v].pm; prio_bus = VEC[v].pb; prio_use = VEC[v].pu;
            cur_prio = VEC[v].cp; ctx = VEC[v].cx;
            stack_push = VEC[v].sp; hard_req = VEC[v].hr;
            step();
            chk($sformatf("R%0d vec%0d sel", VEC[v].rq, v), sel, VEC[v].esel);
            chk($sformatf("R%0d vec%0d id", VEC[v].rq, v), sel_id, VEC[v].eid);
            chk($sformatf("R%0d vec%0d esc", VEC[v].rq, v), escalated, VEC[v].eesc);
        end

        // R9 lockup from hard handler context, then R10 and R11 (nmi exit)
        quiet(); ctx = 3'd4; hard_req = 1; step();
        chk("R9 lock hf", lockup, 1);
        chk("R9 inhibit", exec_inhibit, 1);
        chk("R9 sel", sel, 0);
        quiet(); ctx = 3'd0; flt_req = 3'b001; prio_mm = 0; hard_req = 1; step();
        step();
        chk("R10 sel", sel, 0);
        chk("R10 held", lockup, 1);
        quiet(); nmi = 1; step();
        chk("R11 nmi exit", lockup, 0);

        // R9 escalated fault in NMI context, then R12
        quiet(); ctx = 3'd5; flt_req = 3'b001; prio_mm = 0; cur_prio = 7; step();
        chk("R9 lock nmi", lockup, 1);
        chk("R9 esc", escalated, 1);
        quiet(); nmi = 1; step();
        step();
        chk("R12 nmi keeps", lockup, 1);
        quiet(); dbg_halt = 1; step();
        chk("R12 dbg exit", lockup, 0);

        // R11 debug exit from hard handler lockup
        quiet(); ctx = 3'd4; hard_req = 1; step();
        chk("R11 lock", lockup, 1);
        quiet(); dbg_halt = 1; step();
        chk("R11 dbg exit", lockup, 0);

        // R13 asynchronous reset clears lockup
        quiet(); ctx = 3'd4; hard_req = 1; step();
        chk("R13 lock", lockup, 1);
        quiet();
        #(CLK_NS / 4) rst_n = 0;
        #1;
        chk("R13 async clear", lockup, 0);
        chk("R13 inhibit", exec_inhibit, 0);
        @(negedge clk); rst_n = 1; step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule